// File: doc/BRIEF.md
# PMIC Serial Register Bridge

This block lets a host processor reach the registers of a power-management slave over a narrow request/acknowledge link. On the host side it looks like a small memory-mapped register bank with a combinational read path. A write into the slave window is turned into a queued slave write. A write of a slave offset into the read-command register starts a slave read. The result then appears in the read-data register, next to an echo of the address so that software can confirm which read it is looking at.

Window writes wait in a short FIFO and leave over the link one at a time. A read is held back until every write accepted before it has finished on the link. Offsets outside the slave's address range are refused and recorded, and so are writes that find the FIFO full. A parameter picks one of three address modes. The mode sets the window base, the valid offset range and the bits that are echoed.

Top module: `pmic_reg_bridge`

## Requirements
- R1: After reset the link request is low, the read-data register (host offset 0x2C) reads 0, and the FIFO status register (host offset 0x30) reads 0x0000_0400, which is only the empty bit 10 set.
- R2: A host write at host address WIN_BASE + off, with off below the mode's range, leads to exactly one link write with the write flag 1, link address = off and link data = host data bits 15:0. In the default mode 1, WIN_BASE is 0x8000 and the range is 0x4000.
- R3: A host write of an in-range offset to the read-command register (host offset 0x28) while no read is busy starts a read with no other trigger. Busy (bit 31 of offset 0x2C) reads 1 from the clock edge that accepted the command.
- R4: Busy clears at the same clock edge at which the link acknowledges the read. From then on, bits 15:0 of offset 0x2C hold the value the slave returned.
- R5: Bits 30:16 of offset 0x2C hold the echoed address. In modes 1 and 2 this is command bits 16:2, and in mode 0 it is command bits 14:0.
- R6: In the FIFO status register, bit 11 is set when FIFO_DEPTH writes are queued and bit 10 is set when none are queued. The two bits are never set together.
- R7: A window write that arrives while the FIFO is full is dropped and never reaches the link. It sets bit 12 of offset 0x30, and that bit stays set until reset.
- R8: A window write whose offset is at or above the mode's range (0x1000, 0x4000 or 0x20000 for modes 0, 1 or 2) is dropped. It sets the sticky bit 13 of offset 0x30.
- R9: A link read is only issued once the FIFO is empty and no link write is in flight, so a read never overtakes an earlier write.
- R10: A read command written while busy is set is ignored. The busy read completes with its own echo and data, and no extra link read follows.
- R11: A read command with an offset at or above the range does not start a read. Busy stays clear and the sticky bit 14 of offset 0x30 is set.
- R12: The link request stays high with a stable write flag, address and data until an acknowledge is seen. For a read, the slave data is taken in the cycle of the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_valid | input | 1 | Host access strobe, one cycle per access |
| hb_write | input | 1 | 1 = host write, 0 = host read |
| hb_addr | input | HOST_AW | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, combinational from the current address |
| lnk_req | output | 1 | Link transfer request |
| lnk_wr | output | 1 | Link direction, 1 = write |
| lnk_addr | output | 17 | Slave register offset |
| lnk_wdata | output | 16 | Slave write data |
| lnk_ack | input | 1 | Slave acknowledge, one cycle |
| lnk_rdata | input | 16 | Slave read data, valid with the acknowledge |

## Verification
The assertions check the link on every cycle. The request must stay held with stable fields until acknowledged, and a read may only start from an empty FIFO. They also check that busy rises on an accepted command and falls on the read acknowledge, and that the full and empty bits never coincide. Only the bench scenarios can show that data arrives intact and in order, and that the echo is correct. The same goes for the effects of dropped traffic: overflow, out-of-range writes and reads, and a command written while busy. The bench shows these by counting link transfers in its slave model and by reading back slave locations.

// File: rtl/pmic_bridge_pkg.sv
// Shared constants, types and mode helpers for the serial register bridge.
// Assumes mode 0, 1 or 2; any other value behaves as mode 2.
package pmic_bridge_pkg;

    localparam int LINK_AW = 17;
    localparam int DATA_W  = 16;
    localparam int ECHO_W  = 15;

    // host register offsets
    localparam logic [31:0] OFF_RD_CMD   = 32'h28;
    localparam logic [31:0] OFF_RD_DATA  = 32'h2C;
    localparam logic [31:0] OFF_FIFO_STS = 32'h30;

    // status bit positions
    localparam int STS_EMPTY = 10;
    localparam int STS_FULL  = 11;
    localparam int STS_OVF   = 12;
    localparam int STS_WRNG  = 13;
    localparam int STS_RRNG  = 14;

    typedef struct packed {
        logic [LINK_AW-1:0] addr;
        logic [DATA_W-1:0]  data;
    } wr_entry_t;

    // size of the valid slave offset space
    function automatic logic [31:0] range_of(input int mode);
        case (mode)
            0:       return 32'h0000_1000;
            1:       return 32'h0000_4000;
            default: return 32'h0002_0000;
        endcase
    endfunction

    // host address where the slave window begins
    function automatic logic [31:0] win_base_of(input int mode);
        return (mode >= 2) ? 32'h0002_0000 : 32'h0000_8000;
    endfunction

    // address echo carried back with read data
    function automatic logic [ECHO_W-1:0] echo_of(input int mode, input logic [LINK_AW-1:0] a);
        return (mode == 0) ? a[ECHO_W-1:0] : a[LINK_AW-1:2];
    endfunction

endpackage

// File: rtl/bridge_wfifo.sv
// Write FIFO: holds queued slave writes.
// Assumes the caller never pushes when full and never pops when empty.
module bridge_wfifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    assign head  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/bridge_host_if.sv
// Host register front end: decodes the window and the command register,
// keeps the read result, busy flag and sticky error flags.
// Assumes one-cycle host strobes; reads are answered combinationally.
module bridge_host_if
    import pmic_bridge_pkg::*;
#(
    parameter int MODE    = 1,
    parameter int HOST_AW = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hb_valid,
    input  logic               hb_write,
    input  logic [HOST_AW-1:0] hb_addr,
    input  logic [31:0]        hb_wdata,
    output logic [31:0]        hb_rdata,
    input  logic               wf_full,
    input  logic               wf_empty,
    output logic               push,
    output wr_entry_t          push_entry,
    output logic               rd_busy,
    output logic [LINK_AW-1:0] rd_addr,
    input  logic               rd_done,
    input  logic [DATA_W-1:0]  rd_data
);
    localparam logic [31:0] RANGE    = range_of(MODE);
    localparam logic [31:0] WIN_BASE = win_base_of(MODE);

    logic [31:0]       abs_addr, win_off;
    logic              in_win, off_ok, cmd_ok_rng;
    logic              win_wr, cmd_wr, cmd_take;
    logic [ECHO_W-1:0] echo_q;
    logic [DATA_W-1:0] data_q;
    logic              ovf_q, wrng_q, rrng_q;

    // address decode
    always_comb begin
        abs_addr   = {{(32 - HOST_AW){1'b0}}, hb_addr};
        win_off    = abs_addr - WIN_BASE;
        in_win     = (abs_addr >= WIN_BASE);
        off_ok     = (win_off < RANGE);
        cmd_ok_rng = (hb_wdata < RANGE);
        win_wr     = hb_valid && hb_write && in_win;
        cmd_wr     = hb_valid && hb_write && !in_win && (abs_addr == OFF_RD_CMD);
        cmd_take   = cmd_wr && !rd_busy && cmd_ok_rng;
    end

    // queue entry for an accepted window write
    assign push            = win_wr && off_ok && !wf_full;
    assign push_entry.addr = win_off[LINK_AW-1:0];
    assign push_entry.data = hb_wdata[DATA_W-1:0];

    // read command, busy flag and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy <= 1'b0;
            rd_addr <= '0;
            echo_q  <= '0;
            data_q  <= '0;
        end else if (cmd_take) begin
            rd_busy <= 1'b1;
            rd_addr <= hb_wdata[LINK_AW-1:0];
            echo_q  <= echo_of(MODE, hb_wdata[LINK_AW-1:0]);
        end else if (rd_done) begin
            rd_busy <= 1'b0;
            data_q  <= rd_data;
        end
    end

    // sticky error flags, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            wrng_q <= 1'b0;
            rrng_q <= 1'b0;
        end else begin
            if (win_wr && off_ok && wf_full)           ovf_q  <= 1'b1;
            if (win_wr && !off_ok)                     wrng_q <= 1'b1;
            if (cmd_wr && !rd_busy && !cmd_ok_rng)     rrng_q <= 1'b1;
        end
    end

    // host read mux
    always_comb begin
        hb_rdata = '0;
        if (hb_valid && !hb_write && !in_win) begin
            case (abs_addr)
                OFF_RD_DATA: hb_rdata = {rd_busy, echo_q, data_q};
                OFF_FIFO_STS: begin
                    hb_rdata[STS_EMPTY] = wf_empty;
                    hb_rdata[STS_FULL]  = wf_full;
                    hb_rdata[STS_OVF]   = ovf_q;
                    hb_rdata[STS_WRNG]  = wrng_q;
                    hb_rdata[STS_RRNG]  = rrng_q;
                end
                default: hb_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bridge_link_seq.sv
// Link sequencer: issues one request at a time, writes first, and a read
// only when the FIFO is empty and the link is idle.
// Assumes the slave gives a single-cycle acknowledge per request.
module bridge_link_seq
    import pmic_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wf_empty,
    input  wr_entry_t          wf_head,
    output logic               wf_pop,
    input  logic               rd_pending,
    input  logic [LINK_AW-1:0] rd_addr,
    output logic               rd_done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               lnk_req,
    output logic               lnk_wr,
    output logic [LINK_AW-1:0] lnk_addr,
    output logic [DATA_W-1:0]  lnk_wdata,
    input  logic               lnk_ack,
    input  logic [DATA_W-1:0]  lnk_rdata
);
    typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} seq_st_t;
    seq_st_t st;
    logic    start_rd;

    // launch decisions and read completion
    always_comb begin
        wf_pop   = (st == S_IDLE) && !wf_empty;
        start_rd = (st == S_IDLE) && wf_empty && rd_pending;
        rd_done  = (st == S_RD) && lnk_ack;
        rd_data  = lnk_rdata;
    end

    // request registers and state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            lnk_req   <= 1'b0;
            lnk_wr    <= 1'b0;
            lnk_addr  <= '0;
            lnk_wdata <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (wf_pop) begin
                        st        <= S_WR;
                        lnk_req   <= 1'b1;
                        lnk_wr    <= 1'b1;
                        lnk_addr  <= wf_head.addr;
                        lnk_wdata <= wf_head.data;
                    end else if (start_rd) begin
                        st        <= S_RD;
                        lnk_req   <= 1'b1;
                        lnk_wr    <= 1'b0;
                        lnk_addr  <= rd_addr;
                        lnk_wdata <= '0;
                    end
                end
                default: begin
                    if (lnk_ack) begin
                        st      <= S_IDLE;
                        lnk_req <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pmic_reg_bridge.sv
// Top of the serial register bridge: host front end, write FIFO and link
// sequencer. Assumes a single host master and a single slave.
module pmic_reg_bridge
    import pmic_bridge_pkg::*;
#(
    parameter int MODE       = 1,
    parameter int FIFO_DEPTH = 4,
    parameter int HOST_AW    = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hb_valid,
    input  logic               hb_write,
    input  logic [HOST_AW-1:0] hb_addr,
    input  logic [31:0]        hb_wdata,
    output logic [31:0]        hb_rdata,
    output logic               lnk_req,
    output logic               lnk_wr,
    output logic [16:0]        lnk_addr,
    output logic [15:0]        lnk_wdata,
    input  logic               lnk_ack,
    input  logic [15:0]        lnk_rdata
);
    localparam int ENTRY_W = $bits(wr_entry_t);

    logic               wf_full, wf_empty, wf_push, wf_pop;
    wr_entry_t          push_entry, head_entry;
    logic [ENTRY_W-1:0] head_raw;
    logic               rd_busy, rd_done;
    logic [LINK_AW-1:0] rd_addr;
    logic [DATA_W-1:0]  rd_data;

    assign head_entry = wr_entry_t'(head_raw);

    bridge_host_if #(.MODE(MODE), .HOST_AW(HOST_AW)) u_host (
        .clk(clk), .rst_n(rst_n),
        .hb_valid(hb_valid), .hb_write(hb_write), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .wf_full(wf_full), .wf_empty(wf_empty),
        .push(wf_push), .push_entry(push_entry),
        .rd_busy(rd_busy), .rd_addr(rd_addr),
        .rd_done(rd_done), .rd_data(rd_data)
    );

    bridge_wfifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wf_push), .push_data(push_entry),
        .pop(wf_pop), .head(head_raw),
        .full(wf_full), .empty(wf_empty)
    );

    bridge_link_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .wf_empty(wf_empty), .wf_head(head_entry), .wf_pop(wf_pop),
        .rd_pending(rd_busy), .rd_addr(rd_addr),
        .rd_done(rd_done), .rd_data(rd_data),
        .lnk_req(lnk_req), .lnk_wr(lnk_wr), .lnk_addr(lnk_addr),
        .lnk_wdata(lnk_wdata), .lnk_ack(lnk_ack), .lnk_rdata(lnk_rdata)
    );
endmodule

// File: rtl/pmic_reg_bridge_chk.sv
// Property checker for the bridge, bound into the top module.
// Assumes the same MODE and HOST_AW as the instance it is bound to.
module pmic_reg_bridge_chk
    import pmic_bridge_pkg::*;
#(
    parameter int MODE    = 1,
    parameter int HOST_AW = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hb_valid,
    input logic               hb_write,
    input logic [HOST_AW-1:0] hb_addr,
    input logic [31:0]        hb_wdata,
    input logic               lnk_req,
    input logic               lnk_wr,
    input logic [16:0]        lnk_addr,
    input logic [15:0]        lnk_wdata,
    input logic               lnk_ack,
    input logic               rd_busy,
    input logic               wf_full,
    input logic               wf_empty
);
    localparam logic [31:0] RANGE = range_of(MODE);

    // R12: request and its fields hold until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req && !lnk_ack) |=> (lnk_req && $stable(lnk_wr) && $stable(lnk_addr) && $stable(lnk_wdata)));

    // R9: a read request only starts from an empty FIFO
    p_rd_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lnk_req) && !lnk_wr) |-> $past(wf_empty));

    // R3: an accepted command raises busy at once
    p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && hb_write && hb_addr == HOST_AW'(OFF_RD_CMD) && !rd_busy && hb_wdata < RANGE) |=> rd_busy);

    // R4: busy drops on the read acknowledge
    p_busy_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && lnk_req && !lnk_wr && lnk_ack) |=> !rd_busy);

    // R6: full and empty never together
    p_full_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wf_full && wf_empty));
endmodule

bind pmic_reg_bridge pmic_reg_bridge_chk #(.MODE(MODE), .HOST_AW(HOST_AW)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .hb_valid(hb_valid), .hb_write(hb_write), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .lnk_req(lnk_req), .lnk_wr(lnk_wr), .lnk_addr(lnk_addr), .lnk_wdata(lnk_wdata),
    .lnk_ack(lnk_ack), .rd_busy(rd_busy), .wf_full(wf_full), .wf_empty(wf_empty)
);

// File: tb/pmic_reg_bridge_tb_top.sv
// Directed bench for the bridge with a latency-programmable slave model.
`timescale 1ns/1ps
module pmic_reg_bridge_tb_top;
    localparam int          HAW      = 18;
    localparam logic [31:0] WIN      = 32'h8000;
    localparam logic [31:0] RDCMD    = 32'h28;
    localparam logic [31:0] RDDATA   = 32'h2C;
    localparam logic [31:0] FSTS     = 32'h30;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hb_valid = 1'b0, hb_write = 1'b0;
    logic [HAW-1:0]  hb_addr = '0;
    logic [31:0]     hb_wdata = '0;
    logic [31:0]     hb_rdata;
    logic            lnk_req, lnk_wr, lnk_ack;
    logic [16:0]     lnk_addr;
    logic [15:0]     lnk_wdata, lnk_rdata;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pmic_reg_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .hb_valid(hb_valid), .hb_write(hb_write), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .lnk_req(lnk_req), .lnk_wr(lnk_wr), .lnk_addr(lnk_addr),
        .lnk_wdata(lnk_wdata), .lnk_ack(lnk_ack), .lnk_rdata(lnk_rdata)
    );

    // slave model
    int          lat_cfg = 3;
    int          lat_cnt;
    logic        busy_m;
    int          n_wr, n_rd;
    logic [16:0] last_wr_addr;
    logic [15:0] last_wr_data;
    logic [15:0] smem [256];

    function automatic logic [15:0] init_val(input int i);
        return (16'(i) * 16'h0101) ^ 16'h5A00;
    endfunction

    always @(posedge clk) begin
        lnk_ack <= 1'b0;
        if (!rst_n) begin
            busy_m <= 1'b0; lat_cnt <= 0; n_wr <= 0; n_rd <= 0;
            lnk_rdata <= '0; last_wr_addr <= '0; last_wr_data <= '0;
            for (int i = 0; i < 256; i++) smem[i] <= init_val(i);
        end else if (lnk_req && !busy_m && !lnk_ack) begin
            busy_m <= 1'b1; lat_cnt <= lat_cfg;
        end else if (busy_m) begin
            if (lat_cnt <= 1) begin
                lnk_ack <= 1'b1; busy_m <= 1'b0;
                if (lnk_wr) begin
                    smem[lnk_addr[7:0]] <= lnk_wdata;
                    n_wr <= n_wr + 1; last_wr_addr <= lnk_addr; last_wr_data <= lnk_wdata;
                end else begin
                    lnk_rdata <= smem[lnk_addr[7:0]];
                    n_rd <= n_rd + 1;
                end
            end else lat_cnt <= lat_cnt - 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hb_valid = 1'b1; hb_write = 1'b1; hb_addr = a[HAW-1:0]; hb_wdata = d;
        @(negedge clk);
        hb_valid = 1'b0; hb_write = 1'b0;
    endtask

    task automatic host_rd(input logic [31:0] a, output logic [31:0] d);
        hb_addr = a[HAW-1:0]; hb_valid = 1'b1; hb_write = 1'b0;
        #1 d = hb_rdata;
        hb_valid = 1'b0;
    endtask

    task automatic wait_rd(output logic [31:0] v);
        for (int k = 0; k < 1000; k++) begin
            host_rd(RDDATA, v);
            if (!v[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic slave_read(input logic [16:0] off, output logic [31:0] v);
        host_wr(RDCMD, {15'd0, off});
        wait_rd(v);
    endtask

    logic [31:0] sticky_exp = '0;

    task automatic t_reset;
        logic [31:0] v;
        host_rd(FSTS, v);   chk("R1 status", v, 32'h400);
        host_rd(RDDATA, v); chk("R1 rddata", v, 32'h0);
        chk("R1 req", {31'd0, lnk_req}, 32'h0);
    endtask

    task automatic t_write_fwd;
        int n0 = n_wr;
        host_wr(WIN + 32'h10, 32'hFFFF_BEEF);
        repeat (20) @(negedge clk);
        chk("R2 count", n_wr - n0, 1);
        chk("R2 addr", {15'd0, last_wr_addr}, 32'h10);
        chk("R2 data", {16'd0, last_wr_data}, 32'hBEEF);
        host_wr(WIN + 32'h3FFE, 32'h1234);
        repeat (20) @(negedge clk);
        chk("R2 top addr", {15'd0, last_wr_addr}, 32'h3FFE);
        chk("R2 top data", {16'd0, last_wr_data}, 32'h1234);
    endtask

    task automatic t_read;
        logic [31:0] v;
        host_wr(RDCMD, 32'h10);
        host_rd(RDDATA, v);
        chk("R3 busy set", {31'd0, v[31]}, 32'h1);
        wait_rd(v);
        chk("R4 R5 result", v, {1'b0, 15'h4, 16'hBEEF});
        slave_read(17'h3FFC, v);
        chk("R5 echo top", v, {1'b0, 15'hFFF, init_val(8'hFC)});
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        int n0 = n_rd;
        lat_cfg = 10;
        host_wr(RDCMD, 32'h10);
        host_wr(RDCMD, 32'h20);
        wait_rd(v);
        chk("R10 result", v, {1'b0, 15'h4, 16'hBEEF});
        repeat (30) @(negedge clk);
        chk("R10 reads", n_rd - n0, 1);
        lat_cfg = 3;
    endtask

    task automatic t_rd_range;
        logic [31:0] v;
        int n0 = n_rd;
        host_wr(RDCMD, 32'h4000);
        host_rd(RDDATA, v);
        chk("R11 busy", {31'd0, v[31]}, 32'h0);
        sticky_exp[14] = 1'b1;
        host_rd(FSTS, v);
        chk("R11 flag", v, sticky_exp | 32'h400);
        repeat (20) @(negedge clk);
        chk("R11 reads", n_rd - n0, 0);
    endtask

    task automatic t_order;
        logic [31:0] v;
        int n0 = n_wr;
        lat_cfg = 8;
        host_wr(WIN + 32'h30, 32'h1111);
        repeat (4) @(negedge clk);
        chk("R12 held", {lnk_req, lnk_wr, 13'd0, lnk_addr}, {2'b11, 13'd0, 17'h30});
        host_wr(WIN + 32'h34, 32'h2222);
        slave_read(17'h34, v);
        chk("R9 ordered", v, {1'b0, 15'hD, 16'h2222});
        chk("R9 writes", n_wr - n0, 2);
        lat_cfg = 3;
    endtask

    task automatic t_full;
        logic [31:0] v;
        lat_cfg = 40;
        for (int i = 0; i < 5; i++) host_wr(WIN + 32'h40 + 32'(4 * i), 32'hA000 + 32'(i));
        host_rd(FSTS, v);
        chk("R6 full", v, sticky_exp | 32'h800);
        host_wr(WIN + 32'h60, 32'hDEAD);
        sticky_exp[12] = 1'b1;
        host_rd(FSTS, v);
        chk("R7 overflow", v, sticky_exp | 32'h800);
        repeat (400) @(negedge clk);
        host_rd(FSTS, v);
        chk("R6 R7 drained", v, sticky_exp | 32'h400);
        lat_cfg = 3;
        slave_read(17'h60, v);
        chk("R7 dropped", {16'd0, v[15:0]}, {16'd0, init_val(8'h60)});
        slave_read(17'h50, v);
        chk("R7 last kept", {16'd0, v[15:0]}, 32'hA004);
    endtask

    task automatic t_wr_range;
        logic [31:0] v;
        int n0 = n_wr;
        host_wr(WIN + 32'h4000, 32'h7777);
        repeat (20) @(negedge clk);
        chk("R8 no link", n_wr - n0, 0);
        sticky_exp[13] = 1'b1;
        host_rd(FSTS, v);
        chk("R8 flag", v, sticky_exp | 32'h400);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_fwd;
        t_read;
        t_busy_ignore;
        t_rd_range;
        t_order;
        t_full;
        t_wr_range;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule